// File: doc/BRIEF.md
# Multi-Word Flash Program Sequencer

This block writes a run of consecutive 32-bit words into an embedded flash array. Software loads up to four holding slots and then issues the multi-word program command (code 0x27) with a start address. The sequencer takes the slots in a fixed rotation and drives one flash write per slot. The flash address steps by four bytes for each word.

Every slot has an occupancy flag. A write to the slot sets the flag. Hardware clears it once that slot's word has been written to flash. Software can therefore refill slots while a burst is running and keep the burst going. The burst ends at the first slot the sequencer reaches with its flag clear. It also ends, with a failure indication, when the next address would leave the flash range.

A status byte reports busy, in-progress, fail and the four slot flags. A progress address output shows the word being written and keeps the last address reached once the burst stops. Slot 0 shares its storage with the single-word data register, so the two always hold the same value.

Top module: `mwp_seq`

## Requirements
- R1: After reset, `status`, `prog_addr`, `fl_we`, `fl_addr`, `fl_wdata` and all four slots read as zero.
- R2: A `dat_we` pulse stores `dat_wdata` in slot `dat_idx` and sets status bit 4+`dat_idx` on the next cycle. A `sw_we` pulse stores `dat_wdata` in slot 0 and sets bit 4. Slot 0 read through `rd_idx`=0 then returns that value.
- R3: A `trig` with `trig_cmd`=0x27, a word-aligned start address below `FLASH_BYTES`, and the block idle starts a burst. Words go out in slot order 0,1,2,3,0,... The flash address starts at the start address and grows by 4 per word. Each word carries the slot's contents as they were when that word began.
- R4: Each word holds `fl_we` high for exactly `PROG_CYC` consecutive cycles. The slot's flag clears at the end of the word.
- R5: When the sequencer reaches a slot whose flag is clear, the burst ends. Status bit 0 (busy) and bit 1 (in progress) both drop. `prog_addr` keeps the address of the last word written.
- R6: A slot refilled during a burst is written again when the rotation comes back to it, at the next stepped address.
- R7: A start whose address is not a multiple of 4, or is not below `FLASH_BYTES`, sets the fail flag (status bit 2). It produces no flash write and leaves busy at 0.
- R8: If the next stepped address would reach `FLASH_BYTES`, the burst stops before that word. The fail flag is set, and the remaining slot flags stay set.
- R9: A `fail_clr` pulse clears the fail flag.
- R10: A trigger with any command code other than 0x27 is ignored. So is any trigger while busy. Neither changes the flash writes or the status.
- R11: If software writes a slot in the same cycle that hardware clears its flag, the flag stays set and the slot keeps the new value.
- R12: Busy rises in the cycle after an accepted start. In-progress is high only from the first word until the burst ends, so a start with slot 0 empty shows busy for one cycle and never shows in-progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_we | input | 1 | Write strobe for the slot chosen by `dat_idx` |
| dat_idx | input | 2 | Slot index for `dat_we` |
| sw_we | input | 1 | Write strobe of the single-word data register (slot 0); takes precedence over `dat_we` |
| dat_wdata | input | DATA_W | Data for either write strobe |
| trig | input | 1 | Command start pulse |
| trig_cmd | input | 7 | Command code presented with `trig` |
| trig_addr | input | ADDR_W | Start address presented with `trig` |
| fail_clr | input | 1 | Clears the fail flag |
| rd_idx | input | 2 | Slot selected for `rd_data` |
| rd_data | output | DATA_W | Contents of the selected slot |
| fl_we | output | 1 | Flash word write strobe |
| fl_addr | output | ADDR_W | Flash byte address of the word being written |
| fl_wdata | output | DATA_W | Flash write data |
| status | output | 8 | {flag3, flag2, flag1, flag0, 0, fail, in progress, busy} |
| prog_addr | output | ADDR_W | Current or last programmed address |

## Verification
Two things can hit the same slot flag in one cycle: software refilling the slot, and the sequencer clearing the flag at the end of that slot's word. The bench waits for the word's strobe to rise. It counts `PROG_CYC`-1 falling edges and then writes the slot, so the write lands on the clearing edge. The next slot is empty, so the burst ends after one word. The result is correct if the flag is still set, the slot reads back the new data, and the single flash write carried the old data.

// File: rtl/mwp_pkg.sv
// Shared constants and types of the multi-word program sequencer.
// Assumes exactly four holding slots; the status layout depends on it.
package mwp_pkg;
    localparam int NSLOT  = 4;
    localparam int SLOT_W = 2;
    localparam logic [6:0] CMD_MULTI = 7'h27;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WORD,
        ST_NEXT
    } st_e;
endpackage

// File: rtl/mwp_slots.sv
// Four holding slots, each with an occupancy flag.
// A write stores the data and sets the flag. A clear request from the
// sequencer drops the flag unless a write hits the same slot in that cycle.
module mwp_slots
    import mwp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SLOT_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          clr_en,
    input  logic [SLOT_W-1:0]             clr_idx,
    output logic [NSLOT-1:0]              flags,
    output logic [NSLOT-1:0][DATA_W-1:0]  data
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic              hit;
        logic              flag_q;
        logic [DATA_W-1:0] data_q;

        assign hit = wr_en && (wr_idx == SLOT_W'(s));

        // Store written data; a write outranks the clear of the flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                flag_q <= 1'b0;
            end else if (hit) begin
                data_q <= wr_data;
                flag_q <= 1'b1;
            end else if (clr_en && (clr_idx == SLOT_W'(s))) begin
                flag_q <= 1'b0;
            end
        end

        assign flags[s] = flag_q;
        assign data[s]  = data_q;
    end
endmodule

// File: rtl/mwp_ctrl.sv
// Burst sequencer. It accepts the multi-word command, checks the start
// address, then walks the slots in rotation. Each word is held on the flash
// port for PROG_CYC cycles. The burst stops on an empty slot or at the range end.
// Assumes PROG_CYC >= 1 and FLASH_BYTES a multiple of 4.
module mwp_ctrl
    import mwp_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int unsigned FLASH_BYTES = 32'h0001_0000,
    parameter int          PROG_CYC    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          trig,
    input  logic [6:0]                    trig_cmd,
    input  logic [ADDR_W-1:0]             trig_addr,
    input  logic                          fail_clr,
    input  logic [NSLOT-1:0]              flags,
    input  logic [NSLOT-1:0][DATA_W-1:0]  data,
    output logic                          clr_en,
    output logic [SLOT_W-1:0]             clr_idx,
    output logic                          fl_we,
    output logic [ADDR_W-1:0]             fl_addr,
    output logic [DATA_W-1:0]             fl_wdata,
    output logic                          busy,
    output logic                          active,
    output logic                          fail,
    output logic [ADDR_W-1:0]             prog_addr
);
    localparam int CNT_W = $clog2(PROG_CYC + 1);
    localparam logic [ADDR_W:0]  LIMIT    = (ADDR_W + 1)'(FLASH_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYC - 1);

    st_e               st_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic              fail_q;

    logic [ADDR_W:0]   nxt_ext;
    logic              start_hit;
    logic              start_ok;
    logic              last_cyc;

    // Decode the start request, its address check and the word boundary.
    always_comb begin
        nxt_ext   = {1'b0, addr_q} + (ADDR_W + 1)'(4);
        start_hit = trig && (trig_cmd == CMD_MULTI) && (st_q == ST_IDLE);
        start_ok  = (trig_addr[1:0] == 2'b00) && ({1'b0, trig_addr} < LIMIT);
        last_cyc  = (st_q == ST_WORD) && (cnt_q == CNT_LAST);
    end

    // Burst state machine with address stepping and the fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            slot_q <= '0;
            cnt_q  <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            fail_q <= 1'b0;
        end else begin
            if (fail_clr) fail_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_hit) begin
                        if (start_ok) begin
                            addr_q <= trig_addr;
                            slot_q <= '0;
                            st_q   <= ST_LOAD;
                        end else begin
                            fail_q <= 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (flags[slot_q]) begin
                        wdat_q <= data[slot_q];
                        cnt_q  <= '0;
                        st_q   <= ST_WORD;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_WORD: begin
                    if (last_cyc) begin
                        slot_q <= slot_q + SLOT_W'(1);
                        st_q   <= ST_NEXT;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_NEXT: begin
                    if (!flags[slot_q]) begin
                        st_q <= ST_IDLE;
                    end else if (nxt_ext >= LIMIT) begin
                        fail_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        addr_q <= nxt_ext[ADDR_W-1:0];
                        wdat_q <= data[slot_q];
                        cnt_q  <= '0;
                        st_q   <= ST_WORD;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the flash port, the slot clear request and the status bits.
    always_comb begin
        clr_en    = last_cyc;
        clr_idx   = slot_q;
        fl_we     = (st_q == ST_WORD);
        fl_addr   = addr_q;
        fl_wdata  = wdat_q;
        busy      = (st_q != ST_IDLE);
        active    = (st_q == ST_WORD) || (st_q == ST_NEXT);
        fail      = fail_q;
        prog_addr = addr_q;
    end
endmodule

// File: rtl/mwp_seq.sv
// Top of the multi-word program sequencer. It joins the slot store and the
// burst controller, merges the single-word data path into slot 0,
// and builds the status byte. Assumes the command and the slot writes come
// from one register front end in the clock domain of clk.
module mwp_seq
    import mwp_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int unsigned FLASH_BYTES = 32'h0001_0000,
    parameter int          PROG_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_we,
    input  logic [1:0]        dat_idx,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              trig,
    input  logic [6:0]        trig_cmd,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic              fail_clr,
    input  logic [1:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic [7:0]        status,
    output logic [ADDR_W-1:0] prog_addr
);
    logic                         wr_en;
    logic [SLOT_W-1:0]            wr_idx;
    logic                         clr_en;
    logic [SLOT_W-1:0]            clr_idx;
    logic [NSLOT-1:0]             flags;
    logic [NSLOT-1:0][DATA_W-1:0] data;
    logic                         busy;
    logic                         active;
    logic                         fail;

    // Merge the single-word register path onto slot 0.
    always_comb begin
        wr_en  = dat_we || sw_we;
        wr_idx = sw_we ? SLOT_W'(0) : dat_idx;
    end

    mwp_slots #(.DATA_W(DATA_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (dat_wdata),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .flags   (flags),
        .data    (data)
    );

    mwp_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .FLASH_BYTES (FLASH_BYTES),
        .PROG_CYC    (PROG_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_cmd  (trig_cmd),
        .trig_addr (trig_addr),
        .fail_clr  (fail_clr),
        .flags     (flags),
        .data      (data),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .fl_we     (fl_we),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .busy      (busy),
        .active    (active),
        .fail      (fail),
        .prog_addr (prog_addr)
    );

    // Read mux and status byte assembly.
    always_comb begin
        rd_data = data[rd_idx];
        status  = {flags, 1'b0, fail, active, busy};
    end
endmodule

// File: rtl/mwp_seq_chk.sv
// Port-level checker for mwp_seq, attached through bind below.
module mwp_seq_chk #(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int unsigned FLASH_BYTES = 32'h0001_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dat_we,
    input logic [1:0]        dat_idx,
    input logic              sw_we,
    input logic              trig,
    input logic [6:0]        trig_cmd,
    input logic [ADDR_W-1:0] trig_addr,
    input logic              fail_clr,
    input logic              fl_we,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_wdata,
    input logic [7:0]        status
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(FLASH_BYTES);

    AST_ACTIVE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]); // R12

    AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> (status[0] && status[1])); // R3

    AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> ((fl_addr[1:0] == 2'b00) && ({1'b0, fl_addr} < LIMIT))); // R8

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && $past(fl_we)) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R4

    AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (trig_cmd == 7'h27) && !status[0] && (trig_addr[1:0] != 2'b00))
        |=> (status[2] && !status[0])); // R7

    AST_FLAG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !sw_we) |=> status[4 + int'($past(dat_idx))]); // R2

    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_clr && !trig && !status[0]) |=> !status[2]); // R9
endmodule

bind mwp_seq mwp_seq_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .FLASH_BYTES (FLASH_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_we    (dat_we),
    .dat_idx   (dat_idx),
    .sw_we     (sw_we),
    .trig      (trig),
    .trig_cmd  (trig_cmd),
    .trig_addr (trig_addr),
    .fail_clr  (fail_clr),
    .fl_we     (fl_we),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata),
    .status    (status)
);

// File: tb/mwp_seq_test.sv
// Directed bench for mwp_seq: one task per scenario, each checks its results.
module mwp_seq_test;
    localparam int          PERIOD = 10;
    localparam int          P      = 3;
    localparam logic [31:0] FB     = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dat_we = 1'b0;
    logic [1:0]  dat_idx = '0;
    logic        sw_we = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic        trig = 1'b0;
    logic [6:0]  trig_cmd = '0;
    logic [31:0] trig_addr = '0;
    logic        fail_clr = 1'b0;
    logic [1:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        fl_we;
    logic [31:0] fl_addr;
    logic [31:0] fl_wdata;
    logic [7:0]  status;
    logic [31:0] prog_addr;

    int checks = 0;
    int errs   = 0;

    logic [31:0] log_a [16];
    logic [31:0] log_d [16];
    int          log_len [16];
    int          n_wr = 0;
    int          cur_len = 0;
    bit          prev_we = 1'b0;

    mwp_seq #(.FLASH_BYTES(FB), .PROG_CYC(P)) uut (
        .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .dat_idx(dat_idx),
        .sw_we(sw_we), .dat_wdata(dat_wdata), .trig(trig), .trig_cmd(trig_cmd),
        .trig_addr(trig_addr), .fail_clr(fail_clr), .rd_idx(rd_idx),
        .rd_data(rd_data), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .status(status), .prog_addr(prog_addr)
    );

    always #(PERIOD / 2) clk = ~clk;

    // Flash write log, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            n_wr = 0; cur_len = 0; prev_we = 1'b0;
        end else begin
            if (fl_we && !prev_we) begin
                if (n_wr < 16) begin
                    log_a[n_wr] = fl_addr;
                    log_d[n_wr] = fl_wdata;
                end
                n_wr = n_wr + 1;
                cur_len = 1;
            end else if (fl_we) begin
                cur_len = cur_len + 1;
            end else if (prev_we && n_wr <= 16) begin
                log_len[n_wr - 1] = cur_len;
            end
            prev_we = fl_we;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dat_we = 0; sw_we = 0; trig = 0; fail_clr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_slot(input logic [1:0] idx, input logic [31:0] d);
        dat_we = 1'b1; dat_idx = idx; dat_wdata = d;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic fire(input logic [6:0] cmd, input logic [31:0] a);
        trig = 1'b1; trig_cmd = cmd; trig_addr = a;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_we_high();
        for (int i = 0; i < 100 && !fl_we; i++) @(negedge clk);
    endtask

    task automatic wait_we_low();
        for (int i = 0; i < 100 && fl_we; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && status[0]; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", {24'b0, status}, 32'h0);
        chk("R1 prog_addr", prog_addr, 32'h0);
        chk("R1 fl_we", {31'b0, fl_we}, 32'h0);
        chk("R1 fl_addr", fl_addr, 32'h0);
        chk("R1 fl_wdata", fl_wdata, 32'h0);
        for (int s = 0; s < 4; s++) begin
            rd_idx = 2'(s); #1;
            chk("R1 slot", rd_data, 32'h0);
        end
    endtask

    task automatic t_fill();
        do_reset();
        wr_slot(2'd2, 32'hCAFE_0002);
        chk("R2 flag2", {24'b0, status}, 32'h40);
        wr_slot(2'd0, 32'hCAFE_0000);
        wr_slot(2'd1, 32'hCAFE_0001);
        wr_slot(2'd3, 32'hCAFE_0003);
        chk("R2 all flags", {24'b0, status}, 32'hF0);
        rd_idx = 2'd3; #1;
        chk("R2 read slot3", rd_data, 32'hCAFE_0003);
        sw_we = 1'b1; dat_wdata = 32'h5151_AAAA;
        @(negedge clk);
        sw_we = 1'b0;
        rd_idx = 2'd0; #1;
        chk("R2 single-word mirror", rd_data, 32'h5151_AAAA);
    endtask

    task automatic t_burst();
        do_reset();
        for (int s = 0; s < 4; s++) wr_slot(2'(s), 32'hA000_0000 + 32'(s));
        fire(7'h27, 32'h100);
        chk("R12 busy after start", {30'b0, status[1:0]}, 32'h1);
        wait_we_high();
        chk("R12 in progress", {30'b0, status[1:0]}, 32'h3);
        wait_idle();
        chk("R3 count", 32'(n_wr), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 addr", log_a[i], 32'h100 + 32'(4 * i));
            chk("R3 data", log_d[i], 32'hA000_0000 + 32'(i));
            chk("R4 length", 32'(log_len[i]), 32'(P));
        end
        chk("R4 R5 status", {24'b0, status}, 32'h0);
        chk("R5 last addr", prog_addr, 32'h10C);
    endtask

    task automatic t_partial();
        do_reset();
        wr_slot(2'd0, 32'h11);
        wr_slot(2'd1, 32'h22);
        wr_slot(2'd3, 32'h44);
        fire(7'h27, 32'h200);
        wait_idle();
        chk("R5 count", 32'(n_wr), 32'd2);
        chk("R5 status", {24'b0, status}, 32'h80);
        chk("R5 last addr", prog_addr, 32'h204);
    endtask

    task automatic t_empty_start();
        do_reset();
        fire(7'h27, 32'h600);
        chk("R12 busy only", {30'b0, status[1:0]}, 32'h1);
        @(negedge clk);
        chk("R12 back idle", {24'b0, status}, 32'h0);
        chk("R12 no write", 32'(n_wr), 32'd0);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int s = 0; s < 4; s++) wr_slot(2'(s), 32'hB000_0000 + 32'(s));
        fire(7'h27, 32'h300);
        wait_we_high();
        wait_we_low();
        wait_we_high();
        wr_slot(2'd0, 32'hEEEE_0000);
        wait_idle();
        chk("R6 count", 32'(n_wr), 32'd5);
        chk("R6 wrap addr", log_a[4], 32'h310);
        chk("R6 wrap data", log_d[4], 32'hEEEE_0000);
        chk("R6 first data", log_d[0], 32'hB000_0000);
        chk("R6 last addr", prog_addr, 32'h310);
    endtask

    task automatic t_collide();
        do_reset();
        wr_slot(2'd0, 32'hF1F1_F1F1);
        fire(7'h27, 32'h400);
        wait_we_high();
        repeat (P - 1) @(negedge clk);
        wr_slot(2'd0, 32'hF2F2_F2F2);
        wait_idle();
        chk("R11 count", 32'(n_wr), 32'd1);
        chk("R11 old data", log_d[0], 32'hF1F1_F1F1);
        chk("R11 flag kept", {24'b0, status}, 32'h10);
        rd_idx = 2'd0; #1;
        chk("R11 new data", rd_data, 32'hF2F2_F2F2);
    endtask

    task automatic t_bad_start();
        do_reset();
        wr_slot(2'd0, 32'h1);
        fire(7'h27, 32'h102);
        repeat (3) @(negedge clk);
        chk("R7 misaligned", {24'b0, status}, 32'h14);
        chk("R7 no write", 32'(n_wr), 32'd0);
        fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
        chk("R9 clear", {24'b0, status}, 32'h10);
        fire(7'h27, FB);
        repeat (3) @(negedge clk);
        chk("R7 out of range", {24'b0, status}, 32'h14);
        chk("R7 no write range", 32'(n_wr), 32'd0);
        fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
        chk("R9 clear again", {24'b0, status}, 32'h10);
    endtask

    task automatic t_range_end();
        do_reset();
        for (int s = 0; s < 4; s++) wr_slot(2'(s), 32'hC000_0000 + 32'(s));
        fire(7'h27, FB - 32'd8);
        wait_idle();
        chk("R8 count", 32'(n_wr), 32'd2);
        chk("R8 second addr", log_a[1], FB - 32'd4);
        chk("R8 status", {24'b0, status}, 32'hC4);
        chk("R8 last addr", prog_addr, FB - 32'd4);
    endtask

    task automatic t_ignore();
        do_reset();
        wr_slot(2'd0, 32'h77);
        fire(7'h21, 32'h700);
        repeat (4) @(negedge clk);
        chk("R10 other cmd status", {24'b0, status}, 32'h10);
        chk("R10 other cmd no write", 32'(n_wr), 32'd0);
        wr_slot(2'd1, 32'h88);
        fire(7'h27, 32'h500);
        wait_we_high();
        fire(7'h27, 32'h800);
        wait_idle();
        chk("R10 busy retrigger count", 32'(n_wr), 32'd2);
        chk("R10 addr0", log_a[0], 32'h500);
        chk("R10 addr1", log_a[1], 32'h504);
        chk("R10 status", {24'b0, status}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_burst();
        t_partial();
        t_empty_start();
        t_wrap();
        t_collide();
        t_bad_start();
        t_range_end();
        t_ignore();
        summary();
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        checks++;
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end
endmodule